// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block sits between a byte-wide frame source and a MAC transmit port. Each frame arrives as a sequence of bytes with a valid flag and an end-of-frame flag. It leaves as the same bytes, in the same order, with a registered valid flag and end-of-frame flag. Two per-frame options extend the frame. Zero padding lengthens a short frame to the Ethernet minimum. A 32-bit frame check sequence can be appended after the last byte. Turning padding on always turns the check sequence on as well.

A run/stop control decides when frames are admitted. Raising the transmit enable moves the block into its running state, and new frames are accepted only there. Lowering the enable never cuts a frame short: the frame already in progress is sent to the end, and only then does the block stop. The option bits are captured with the first byte of each frame. Changing them in the middle of a frame has no effect on that frame.

Top module: `eth_tx_framer`

## Requirements
- R1: Out of reset, `tx_running` is 0, `out_valid` is 0 and `in_ready` is 0.
- R2: With both options off, the output carries the accepted input bytes in order, one output byte per accepted byte, appearing one cycle after acceptance. `out_last` is 1 only on the final byte.
- R3: With the check option on, four extra bytes follow the last frame byte. They hold the bitwise inverse of a CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF) computed over all earlier output bytes of the frame, least significant byte first. `out_last` marks the fourth of these bytes.
- R4: With padding on, a frame of fewer than 60 data bytes is followed by 0x00 bytes up to 60, then the check sequence, giving 64 output bytes. A frame of 60 or more data bytes gets no padding.
- R5: Padding on forces the check sequence on, whatever `crc_en` says.
- R6: While stopped, raising `tx_enable` sets `tx_running` one cycle later. `in_ready` is 1 only while running, and no input is taken and no output is produced while stopped.
- R7: Lowering `tx_enable` during a frame lets that whole frame, including any padding and check bytes, be sent. `tx_running` is still 1 when `out_last` appears and falls on the next cycle. After that no further frame is admitted.
- R8: `in_ready` is 0 during every cycle in which the block is producing a padding or check byte.
- R9: `pad_en` and `crc_en` are sampled together with the first accepted byte of a frame. Changes during the frame have no effect on it.
- R10: Idle cycles on `in_valid` inside a frame leave the output byte sequence unchanged; they only add gaps where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Run request: 1 starts, 0 stops after the current frame |
| pad_en | input | 1 | Pad short frames with zeros (also forces the check sequence) |
| crc_en | input | 1 | Append a CRC-32 check sequence |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| tx_running | output | 1 | 1 while running, 0 while stopped |

## Verification
The embedded assertions check, on every cycle, the properties that are local in time. The end marker is always a valid byte, and it follows the fourth check byte. Padding implies the check sequence and reaches the 60-byte floor. The latched options are stable while a frame is in progress. The block never stops with a frame open, and input is taken only while running. The byte-level content can only be shown by the bench's sweeps, which compare each frame end to end against arithmetically computed expectations: zero fill, CRC value and byte order, exact frame lengths near the 60-byte boundary, mid-frame option changes, input gaps and a graceful stop followed by a restart.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAD  = 2'd2,
    ST_FCS  = 2'd3
  } seq_state_t;

  localparam logic [31:0] FCS_SEED = 32'hFFFF_FFFF;

  // One byte of a reflected CRC, least significant bit first.
  function automatic logic [31:0] fcs_step(input logic [31:0] cur,
                                           input logic [7:0]  din,
                                           input logic [31:0] poly);
    logic [31:0] r;
    r = cur ^ {24'd0, din};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_fcs_calc.sv
module eth_tx_fcs_calc #(
  parameter logic [31:0] POLY = 32'hEDB8_8320
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        update,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import eth_tx_pkg::*;

  logic [31:0] base;

  assign base = restart ? FCS_SEED : crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= FCS_SEED;
    end else if (update) begin
      crc_q <= fcs_step(base, din, POLY);
    end else if (restart) begin
      crc_q <= FCS_SEED;
    end
  end

endmodule

// File: rtl/eth_tx_run_ctrl.sv
module eth_tx_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tx_enable,
  input  logic frame_busy,
  output logic running
);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (!running) begin
      running <= tx_enable;
    end else begin
      running <= tx_enable | frame_busy;
    end
  end

  a_r7_no_stop_midframe: assert property (@(posedge clk) disable iff (rst)
    (running && frame_busy) |=> running);

  a_r6_start_from_stop: assert property (@(posedge clk) disable iff (rst)
    (!running && tx_enable) |=> running);

endmodule

// File: rtl/eth_tx_frame_seq.sv
module eth_tx_frame_seq #(
  parameter int MIN_DATA = 60,
  parameter int FCS_BYTES = 4,
  localparam int CNT_W = $clog2(MIN_DATA + 1),
  localparam int IDX_W = $clog2(FCS_BYTES)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        running,
  input  logic        tx_enable,
  input  logic        pad_en,
  input  logic        crc_en,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  input  logic [31:0] crc_val,
  output logic        crc_restart,
  output logic        crc_update,
  output logic [7:0]  crc_din,
  output logic        frame_busy,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last
);
  import eth_tx_pkg::*;

  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MIN_DATA);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FCS_BYTES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             pad_l;
  logic             crc_l;

  logic             at_start;
  logic             accept;
  logic             pad_eff;
  logic             crc_eff;
  logic [CNT_W-1:0] cnt_next;

  assign at_start = (state == ST_IDLE);
  assign in_ready = (at_start && running && tx_enable) || (state == ST_DATA);
  assign accept   = in_valid && in_ready;

  assign pad_eff  = at_start ? pad_en : pad_l;
  assign crc_eff  = at_start ? (crc_en | pad_en) : crc_l;

  always_comb begin
    if (at_start) begin
      cnt_next = CNT_W'(1);
    end else if (cnt_q == CNT_CAP) begin
      cnt_next = cnt_q;
    end else begin
      cnt_next = cnt_q + 1'b1;
    end
  end

  assign frame_busy  = !at_start;
  assign crc_restart = at_start;
  assign crc_update  = accept || (state == ST_PAD);
  assign crc_din     = (state == ST_PAD) ? 8'h00 : in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      pad_l     <= 1'b0;
      crc_l     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DATA: begin
          if (accept) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            cnt_q     <= cnt_next;
            if (at_start) begin
              pad_l <= pad_en;
              crc_l <= crc_en | pad_en;
            end
            if (in_last) begin
              idx_q <= '0;
              if (pad_eff && (cnt_next < CNT_CAP)) begin
                state <= ST_PAD;
              end else if (crc_eff) begin
                state <= ST_FCS;
              end else begin
                state    <= ST_IDLE;
                out_last <= 1'b1;
              end
            end else begin
              state <= ST_DATA;
            end
          end
        end
        ST_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          cnt_q     <= cnt_next;
          if (cnt_next == CNT_CAP) begin
            state <= ST_FCS;
          end
        end
        ST_FCS: begin
          out_valid <= 1'b1;
          out_data  <= ~crc_val[{idx_q, 3'b000} +: 8];
          idx_q     <= idx_q + 1'b1;
          if (idx_q == IDX_END) begin
            state    <= ST_IDLE;
            out_last <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r3_fcs_ends_frame: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FCS && idx_q == IDX_END) |=> (out_last && out_valid));

  a_r4_pad_floor: assert property (@(posedge clk) disable iff (rst)
    (out_last && pad_l) |-> (cnt_q == CNT_CAP));

  a_r5_pad_forces_fcs: assert property (@(posedge clk) disable iff (rst)
    pad_l |-> crc_l);

  a_r8_no_ready_filling: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAD || state == ST_FCS) |-> !in_ready);

  a_r9_opts_held: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(pad_l) && $stable(crc_l)));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int          MIN_FRAME = 64,
  parameter logic [31:0] FCS_POLY  = 32'hEDB8_8320,
  localparam int         FCS_BYTES = 4,
  localparam int         MIN_DATA  = MIN_FRAME - FCS_BYTES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_enable,
  input  logic       pad_en,
  input  logic       crc_en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       tx_running
);

  logic        frame_busy;
  logic        crc_restart;
  logic        crc_update;
  logic [7:0]  crc_din;
  logic [31:0] crc_val;

  eth_tx_run_ctrl u_run (
    .clk        (clk),
    .rst        (rst),
    .tx_enable  (tx_enable),
    .frame_busy (frame_busy),
    .running    (tx_running)
  );

  eth_tx_frame_seq #(
    .MIN_DATA  (MIN_DATA),
    .FCS_BYTES (FCS_BYTES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .running     (tx_running),
    .tx_enable   (tx_enable),
    .pad_en      (pad_en),
    .crc_en      (crc_en),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .crc_val     (crc_val),
    .crc_restart (crc_restart),
    .crc_update  (crc_update),
    .crc_din     (crc_din),
    .frame_busy  (frame_busy),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last)
  );

  eth_tx_fcs_calc #(
    .POLY (FCS_POLY)
  ) u_fcs (
    .clk     (clk),
    .rst     (rst),
    .restart (crc_restart),
    .update  (crc_update),
    .din     (crc_din),
    .crc_q   (crc_val)
  );

  a_r6_ready_needs_run: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_running);

  a_r7_running_at_end: assert property (@(posedge clk) disable iff (rst)
    (frame_busy && tx_running) |=> tx_running);

endmodule

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_enable = 1'b0;
  logic       pad_en = 1'b0;
  logic       crc_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       tx_running;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [7:0] obuf [0:127];
  logic [7:0] ebuf [0:127];
  int  ocount = 0;
  int  cur_len = 0;
  int  last_at = -1;
  int  ready_viol = 0;
  bit  done = 0;
  bit  run_at_last = 0;

  always #5 clk = ~clk;

  eth_tx_framer uut (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .pad_en(pad_en), .crc_en(crc_en),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .tx_running(tx_running)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      summary();
    end
  end

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ocount < 128) obuf[ocount] = out_data;
      if (ocount >= cur_len && !out_last && in_ready) ready_viol++;
      if (out_last && !done) begin
        done = 1;
        last_at = ocount;
        run_at_last = tx_running;
      end
      ocount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ ebuf[i][b];
        c = (c >> 1) ^ (fb ? 32'hEDB8_8320 : 32'h0);
      end
    end
    return ~c;
  endfunction

  // Sends one frame and checks it. stop_after >= 0 drops tx_enable after that byte.
  task automatic run_frame(input int len, input bit pad, input bit crc,
                           input bit gaps, input bit flip, input int stop_after,
                           input string req);
    int  elen;
    bit  acc;
    int  bad_at;
    logic [31:0] f;
    @(negedge clk);
    pad_en = pad;
    crc_en = crc;
    for (int i = 0; i < len; i++) ebuf[i] = 8'((i * 37 + len * 11 + 5) & 255);
    elen = len;
    if (pad && elen < 60) begin
      for (int i = len; i < 60; i++) ebuf[i] = 8'h00;
      elen = 60;
    end
    if (pad || crc) begin
      f = ref_fcs(elen);
      for (int k = 0; k < 4; k++) ebuf[elen + k] = f[8*k +: 8];
      elen += 4;
    end
    cur_len = len; ocount = 0; done = 0; last_at = -1; ready_viol = 0;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = ebuf[i];
      in_last  = (i == len - 1);
      do begin
        acc = in_ready;
        @(negedge clk);
      end while (!acc);
      if (flip && i == 0) begin
        pad_en = ~pad;
        crc_en = ~crc;
      end
      if (i == stop_after) tx_enable = 1'b0;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int w = 0; w < 300 && !done; w++) @(negedge clk);
    @(negedge clk);
    bad_at = -1;
    for (int i = 0; i < elen && i < 128; i++)
      if (bad_at < 0 && obuf[i] !== ebuf[i]) bad_at = i;
    check(ocount == elen, req, $sformatf("len=%0d pad=%0d crc=%0d byte count", len, pad, crc),
          ocount, elen);
    if (bad_at >= 0)
      check(0, req, $sformatf("len=%0d byte %0d", len, bad_at), obuf[bad_at], ebuf[bad_at]);
    else
      check(1, req, "bytes", 0, 0);
    check(last_at == elen - 1, req, "out_last position", last_at, elen - 1);
    check(ready_viol == 0, "R8", "in_ready high while filling", ready_viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(tx_running == 1'b0, "R1", "tx_running after reset", tx_running, 0);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);

    // R6: nothing taken while stopped
    in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
    begin
      int leaks = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (out_valid || in_ready) leaks++;
      end
      check(leaks == 0, "R6", "activity while stopped", leaks, 0);
    end
    in_valid = 1'b0; in_last = 1'b0;

    // R6: start
    tx_enable = 1'b1;
    @(negedge clk);
    check(tx_running == 1'b1, "R6", "running one cycle after enable", tx_running, 1);
    check(in_ready == 1'b1, "R6", "ready once running", in_ready, 1);

    // R2 R3 R4 R5 R10: sweep of lengths and option settings
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int len = 1; len <= 66; len++) begin
        run_frame(len, cfg[1], cfg[0], (len % 3 == 0), 1'b0, -1,
                  cfg == 0 ? "R2" : (cfg == 1 ? "R3" : (cfg == 2 ? "R5" : "R4")));
      end
    end
    // R4 boundary around 60 data bytes, with gaps (R10)
    run_frame(59, 1'b1, 1'b0, 1'b1, 1'b0, -1, "R4");
    run_frame(60, 1'b1, 1'b0, 1'b1, 1'b0, -1, "R4");
    run_frame(61, 1'b1, 1'b1, 1'b1, 1'b0, -1, "R10");

    // R9: mid-frame option changes ignored
    run_frame(10, 1'b0, 1'b0, 1'b0, 1'b1, -1, "R9");
    run_frame(10, 1'b1, 1'b0, 1'b0, 1'b1, -1, "R9");
    run_frame(70, 1'b0, 1'b1, 1'b0, 1'b1, -1, "R9");

    // R7: graceful stop mid-frame with padding
    run_frame(12, 1'b1, 1'b0, 1'b0, 1'b0, 1, "R7");
    check(run_at_last == 1'b1, "R7", "running at frame end", run_at_last, 1);
    check(tx_running == 1'b0, "R7", "stopped after frame", tx_running, 0);
    check(in_ready == 1'b0, "R7", "no admission after stop", in_ready, 0);
    in_valid = 1'b1; in_data = 8'h3C; in_last = 1'b1;
    begin
      int leaks = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (out_valid) leaks++;
      end
      check(leaks == 0, "R7", "output after stop", leaks, 0);
    end
    in_valid = 1'b0; in_last = 1'b0;

    // R6: restart and send again
    tx_enable = 1'b1;
    @(negedge clk);
    check(tx_running == 1'b1, "R6", "restart", tx_running, 1);
    run_frame(20, 1'b0, 1'b1, 1'b0, 1'b0, -1, "R6");

    summary();
  end

endmodule